// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations in a small table that any slot can fill. A virtual address arrives with an address-space identifier. Every slot compares its stored page number against the page number of the address, and the first valid slot that agrees reports its frame number. Each slot carries its own page mask, so one slot can cover a run of pages. A slot can also be marked global, which lets it serve every address space.

Software-style maintenance uses plain control pins. An indexed write replaces one slot, and a flush empties the table. A separate probe port returns only the slot number, or a not-found code. A rotating replacement pointer exposes one slot at a time, and it can be stepped on request.

Two address checks sit beside the lookup. One flags addresses in the uncacheable, strictly ordered region. The other flags instruction fetches that are not word aligned; such a fetch reports a fault instead of a hit. Lookup and probe are combinational with no handshake: the answer is valid in the same cycle as the request, and there is nothing to stall. Writes, flush and pointer steps take effect at the next rising clock edge.

Top module: `tlb_xlate`

## Requirements
- R1: A slot matches when `lk_va[31:12]` and its stored page number agree on every bit that is clear in its page mask; bits set in the mask are ignored.
- R2: A page-number match is a hit only if the slot's global bit is 1 or its stored identifier equals `lk_asid`.
- R3: Only a slot with at least one of its two valid bits set takes part in lookup or probe.
- R4: When several slots hit, the lowest index is reported on `lk_idx`, with its frame on `lk_pfn` and `lk_pa = {lk_pfn, lk_va[11:0]}`. On a miss, `lk_idx` and `lk_pfn` read zero.
- R5: `pr_idx` gives the index of the lowest matching slot for `pr_vpn`/`pr_asid`, zero-extended to 4 bits, or all ones (15) when nothing matches.
- R6: A write whose `wr_idx` is below the slot count replaces that whole slot at the next edge. A write whose index is at or above the slot count leaves the table unchanged. It sets `wr_warn` for exactly the following cycle.
- R7: `flush_en` clears every slot to zero and returns `vr_ptr` to zero at the next edge. It takes priority over a write or a pointer step in the same cycle.
- R8: The `vr_*` outputs show the slot under `vr_ptr`. `vr_adv` steps the pointer by one at the next edge, and the pointer wraps from the last slot to zero.
- R9: `lk_uncache` is 1 exactly when `lk_va` ANDed with 0xA0000000 equals 0xA0000000.
- R10: With `lk_fetch` high and either of `lk_va[1:0]` set, `lk_align_fault` is 1 and `lk_hit` is 0. Without `lk_fetch`, the low bits do not matter.
- R11: After reset every slot is empty, `vr_ptr` is 0 and `wr_warn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | 3 | Index of hitting slot |
| lk_pfn | output | 20 | Frame number of hitting slot |
| lk_pa | output | 32 | Translated physical address |
| lk_uncache | output | 1 | Address lies in uncacheable region |
| lk_align_fault | output | 1 | Misaligned instruction fetch |
| pr_vpn | input | 20 | Probe page number |
| pr_asid | input | 8 | Probe identifier |
| pr_idx | output | 4 | Probe result index or 15 for not found |
| wr_en | input | 1 | Indexed write request |
| wr_idx | input | 4 | Target slot of write |
| wr_vpn | input | 20 | Written page number |
| wr_mask | input | 20 | Written page mask |
| wr_asid | input | 8 | Written identifier |
| wr_glob | input | 1 | Written global bit |
| wr_valid | input | 2 | Written valid pair |
| wr_pfn | input | 20 | Written frame number |
| wr_warn | output | 1 | Previous cycle wrote out of range |
| flush_en | input | 1 | Clear all slots |
| vr_adv | input | 1 | Step replacement pointer |
| vr_ptr | output | 3 | Replacement pointer |
| vr_vpn | output | 20 | Page number of slot under pointer |
| vr_mask | output | 20 | Mask of slot under pointer |
| vr_asid | output | 8 | Identifier of slot under pointer |
| vr_glob | output | 1 | Global bit of slot under pointer |
| vr_valid | output | 2 | Valid pair of slot under pointer |
| vr_pfn | output | 20 | Frame number of slot under pointer |

## Verification
A flush can arrive in the same cycle as an indexed write and as a replacement-pointer step. The bench first moves the pointer away from zero. It then raises all three controls in one cycle, with the write aimed at a fresh page number. On the next cycle it expects the pointer at zero, the slot under it empty, and a probe for the fresh page and for a previously loaded page both returning the not-found code. A later plain write of the same page then shows that the write path itself still works.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int ASID_W = 8;
  localparam int PFN_W  = 20;
  localparam logic [VA_W-1:0] UNC_PAT = 32'hA000_0000;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [1:0]        valid;
    logic [PFN_W-1:0]  pfn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  tlb_entry_t [ENTRIES-1:0] tbl,
  input  logic [VPN_W-1:0]         vpn,
  input  logic [ASID_W-1:0]        asid,
  output logic                     hit,
  output logic [SLOT_W-1:0]        idx,
  output logic [PFN_W-1:0]         pfn
);
  logic [ENTRIES-1:0] sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    // page compare on unmasked bits, then identifier or global qualification
    assign sel[g] = (|tbl[g].valid)
                 && (((vpn ^ tbl[g].vpn) & ~tbl[g].mask) == '0)
                 && (tbl[g].glob || (tbl[g].asid == asid));
  end

  // lowest index wins: scan downward so the last assignment is the smallest
  always_comb begin
    hit = |sel;
    idx = '0;
    pfn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (sel[i]) begin
        idx = SLOT_W'(i);
        pfn = tbl[i].pfn;
      end
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int CODE_W = SLOT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     wr_en,
  input  logic [CODE_W-1:0]        wr_idx,
  input  tlb_entry_t               wr_data,
  output tlb_entry_t [ENTRIES-1:0] tbl,
  output logic                     warn
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  tbl[g] <= '0;
      else if (flush)                              tbl[g] <= '0;
      else if (wr_en && wr_idx == CODE_W'(g))      tbl[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn <= 1'b0;
    else        warn <= wr_en && (wr_idx >= CODE_W'(ENTRIES));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              adv,
  output logic [SLOT_W-1:0] ptr
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (flush)   ptr <= '0;
    else if (adv)     ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int CODE_W = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_fetch,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_idx,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [VA_W-1:0]   lk_pa,
  output logic              lk_uncache,
  output logic              lk_align_fault,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic [CODE_W-1:0] pr_idx,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glob,
  input  logic [1:0]        wr_valid,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic              wr_warn,
  input  logic              flush_en,
  input  logic              vr_adv,
  output logic [SLOT_W-1:0] vr_ptr,
  output logic [VPN_W-1:0]  vr_vpn,
  output logic [VPN_W-1:0]  vr_mask,
  output logic [ASID_W-1:0] vr_asid,
  output logic              vr_glob,
  output logic [1:0]        vr_valid,
  output logic [PFN_W-1:0]  vr_pfn
);
  tlb_entry_t [ENTRIES-1:0] tbl;
  tlb_entry_t               wr_data;
  tlb_entry_t               cur;
  logic                     lk_raw_hit, pr_hit;
  logic [SLOT_W-1:0]        lk_raw_idx, pr_raw_idx;
  logic [PFN_W-1:0]         lk_raw_pfn, pr_unused_pfn;

  assign wr_data = '{vpn: wr_vpn, mask: wr_mask, asid: wr_asid, glob: wr_glob,
                     valid: wr_valid, pfn: wr_pfn};

  tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_en), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .tbl(tbl), .warn(wr_warn));

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush_en), .adv(vr_adv), .ptr(vr_ptr));

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .tbl(tbl), .vpn(lk_va[VA_W-1:OFS_W]), .asid(lk_asid),
    .hit(lk_raw_hit), .idx(lk_raw_idx), .pfn(lk_raw_pfn));

  tlb_match #(.ENTRIES(ENTRIES)) u_pr_match (
    .tbl(tbl), .vpn(pr_vpn), .asid(pr_asid),
    .hit(pr_hit), .idx(pr_raw_idx), .pfn(pr_unused_pfn));

  // address-side checks
  assign lk_align_fault = lk_fetch && (lk_va[1:0] != 2'b00);
  assign lk_uncache     = (lk_va & UNC_PAT) == UNC_PAT;

  assign lk_hit = lk_raw_hit && !lk_align_fault;
  assign lk_idx = lk_hit ? lk_raw_idx : '0;
  assign lk_pfn = lk_hit ? lk_raw_pfn : '0;
  assign lk_pa  = {lk_pfn, lk_va[OFS_W-1:0]};

  assign pr_idx = pr_hit ? {1'b0, pr_raw_idx} : '1;

  assign cur      = tbl[vr_ptr];
  assign vr_vpn   = cur.vpn;
  assign vr_mask  = cur.mask;
  assign vr_asid  = cur.asid;
  assign vr_glob  = cur.glob;
  assign vr_valid = cur.valid;
  assign vr_pfn   = cur.pfn;
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int SLOT_W = $clog2(ENTRIES),
  localparam int CODE_W = SLOT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush_en,
  input logic              wr_en,
  input logic [CODE_W-1:0] wr_idx,
  input logic              wr_warn,
  input logic              vr_adv,
  input logic [SLOT_W-1:0] vr_ptr,
  input logic [VPN_W-1:0]  vr_vpn,
  input logic [1:0]        vr_valid,
  input logic [VA_W-1:0]   lk_va,
  input logic              lk_fetch,
  input logic              lk_hit,
  input logic [SLOT_W-1:0] lk_idx,
  input logic [CODE_W-1:0] pr_idx
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(ENTRIES - 1);

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en |=> (vr_ptr == '0) && (vr_valid == 2'b00));

  p_warn_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= CODE_W'(ENTRIES)) |=> wr_warn);

  p_oob_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= CODE_W'(ENTRIES) && !flush_en && !vr_adv)
      |=> ($stable(vr_vpn) && $stable(vr_valid)));

  p_ptr_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vr_adv && !flush_en && vr_ptr == LAST) |=> (vr_ptr == '0));

  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vr_adv && !flush_en) |=> $stable(vr_ptr));

  p_fetch_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fetch && lk_va[1:0] != 2'b00) |-> !lk_hit);

  p_miss_idx_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0));

  p_probe_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_idx[CODE_W-1] == 1'b1) |-> (pr_idx == '1));
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_en(flush_en), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_warn(wr_warn), .vr_adv(vr_adv), .vr_ptr(vr_ptr),
  .vr_vpn(vr_vpn), .vr_valid(vr_valid), .lk_va(lk_va), .lk_fetch(lk_fetch),
  .lk_hit(lk_hit), .lk_idx(lk_idx), .pr_idx(pr_idx));

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_fetch = 1'b0;
  logic        lk_hit, lk_uncache, lk_align_fault;
  logic [2:0]  lk_idx;
  logic [19:0] lk_pfn;
  logic [31:0] lk_pa;
  logic [19:0] pr_vpn = '0;
  logic [7:0]  pr_asid = '0;
  logic [3:0]  pr_idx;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0, wr_mask = '0, wr_pfn = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glob = 1'b0;
  logic [1:0]  wr_valid = '0;
  logic        wr_warn;
  logic        flush_en = 1'b0, vr_adv = 1'b0;
  logic [2:0]  vr_ptr;
  logic [19:0] vr_vpn, vr_mask, vr_pfn;
  logic [7:0]  vr_asid;
  logic        vr_glob;
  logic [1:0]  vr_valid;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  tlb_xlate i_tlb_xlate (.*);

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        fetch;
    logic        hit;
    logic [2:0]  idx;
    logic [19:0] pfn;
    logic        fault;
  } vec_t;

  // R1 mask, R2 identifier/global, R3 valid, R4 priority, R10 alignment
  localparam vec_t VECS [10] = '{
    '{32'h0001_0123, 8'd5, 1'b0, 1'b1, 3'd0, 20'h00AAA, 1'b0},  // exact, R4 e0 before e4
    '{32'h0001_0000, 8'd6, 1'b0, 1'b1, 3'd4, 20'h00EEE, 1'b0},  // R2 global slot 4
    '{32'h0002_F000, 8'd3, 1'b0, 1'b1, 3'd1, 20'h00BBB, 1'b0},  // R1 masked low nibble
    '{32'h0002_5004, 8'd4, 1'b0, 1'b0, 3'd0, 20'h00000, 1'b0},  // R2 wrong identifier
    '{32'h0003_0000, 8'd0, 1'b0, 1'b1, 3'd2, 20'h00CCC, 1'b0},  // R2 global any id
    '{32'h0004_0000, 8'd5, 1'b0, 1'b0, 3'd0, 20'h00000, 1'b0},  // R3 invalid slot
    '{32'h0003_1000, 8'd9, 1'b0, 1'b0, 3'd0, 20'h00000, 1'b0},  // R1 unmasked bit differs
    '{32'h0001_0002, 8'd5, 1'b1, 1'b0, 3'd0, 20'h00000, 1'b1},  // R10 misaligned fetch
    '{32'h0001_0004, 8'd5, 1'b1, 1'b1, 3'd0, 20'h00AAA, 1'b0},  // R10 aligned fetch
    '{32'h0003_0002, 8'd0, 1'b0, 1'b1, 3'd2, 20'h00CCC, 1'b0}   // R10 data ignores low bits
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [3:0] idx, input logic [19:0] vpn, input logic [19:0] mask,
                     input logic [7:0] asid, input logic g, input logic [1:0] v,
                     input logic [19:0] pfn);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_mask = mask;
    wr_asid = asid; wr_glob = g; wr_valid = v; wr_pfn = pfn;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step();
    @(negedge clk); vr_adv = 1'b1;
    @(negedge clk); vr_adv = 1'b0;
  endtask

  task automatic probe(input logic [19:0] vpn, input logic [7:0] asid);
    pr_vpn = vpn; pr_asid = asid; #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R11 ptr", 64'(vr_ptr), 64'd0);
    check("R11 valid", 64'(vr_valid), 64'd0);
    check("R11 warn", 64'(wr_warn), 64'd0);
    check("R11 lookup miss", 64'(lk_hit), 64'd0);
    probe(20'h0, 8'h0);
    check("R3 empty probe", 64'(pr_idx), 64'd15);

    put(4'd0, 20'h00010, 20'h0,     8'd5, 1'b0, 2'b01, 20'h00AAA);
    put(4'd1, 20'h00020, 20'h0000F, 8'd3, 1'b0, 2'b10, 20'h00BBB);
    put(4'd2, 20'h00030, 20'h0,     8'd9, 1'b1, 2'b01, 20'h00CCC);
    put(4'd3, 20'h00040, 20'h0,     8'd5, 1'b0, 2'b00, 20'h00DDD);
    put(4'd4, 20'h00010, 20'h0,     8'd5, 1'b1, 2'b11, 20'h00EEE);

    foreach (VECS[k]) begin
      @(negedge clk);
      lk_va = VECS[k].va; lk_asid = VECS[k].asid; lk_fetch = VECS[k].fetch; #1;
      check($sformatf("R1/R2 R3 R4 R10 vec%0d hit", k), 64'(lk_hit), 64'(VECS[k].hit));
      check($sformatf("R4 vec%0d idx", k), 64'(lk_idx), 64'(VECS[k].idx));
      check($sformatf("R4 vec%0d pfn", k), 64'(lk_pfn), 64'(VECS[k].pfn));
      check($sformatf("R10 vec%0d fault", k), 64'(lk_align_fault), 64'(VECS[k].fault));
    end
    check("R4 pa", 64'(lk_pa), 64'h00CCC002);
    lk_fetch = 1'b0;

    probe(20'h00025, 8'd3); check("R5 probe masked", 64'(pr_idx), 64'd1);
    probe(20'h00055, 8'd3); check("R5 probe none", 64'(pr_idx), 64'd15);
    probe(20'h00010, 8'd7); check("R5 probe global", 64'(pr_idx), 64'd4);

    check("R8 slot0 vpn", 64'(vr_vpn), 64'h10);
    repeat (4) step();
    #1;
    check("R8 ptr 4", 64'(vr_ptr), 64'd4);
    check("R8 slot4 pfn", 64'(vr_pfn), 64'hEEE);
    check("R8 slot4 valid", 64'(vr_valid), 64'd3);
    repeat (4) step();
    #1;
    check("R8 wrap", 64'(vr_ptr), 64'd0);

    // out-of-range write
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd9; wr_vpn = 20'h00070; wr_mask = '0;
    wr_glob = 1'b1; wr_valid = 2'b11; wr_pfn = 20'h00777;
    @(negedge clk); wr_en = 1'b0; #1;
    check("R6 warn set", 64'(wr_warn), 64'd1);
    probe(20'h00070, 8'd0); check("R6 oob ignored", 64'(pr_idx), 64'd15);
    check("R6 slot0 kept", 64'(vr_vpn), 64'h10);
    @(negedge clk); #1;
    check("R6 warn one cycle", 64'(wr_warn), 64'd0);

    // flush against write and step in the same cycle
    repeat (3) step();
    @(negedge clk);
    flush_en = 1'b1; vr_adv = 1'b1;
    wr_en = 1'b1; wr_idx = 4'd2; wr_vpn = 20'h00060; wr_glob = 1'b1;
    wr_valid = 2'b01; wr_pfn = 20'h00123;
    @(negedge clk);
    flush_en = 1'b0; vr_adv = 1'b0; wr_en = 1'b0; #1;
    check("R7 ptr zero", 64'(vr_ptr), 64'd0);
    check("R7 slot empty", 64'(vr_valid), 64'd0);
    probe(20'h00060, 8'd0); check("R7 write lost", 64'(pr_idx), 64'd15);
    probe(20'h00010, 8'd5); check("R7 old gone", 64'(pr_idx), 64'd15);

    put(4'd5, 20'h00060, 20'h0, 8'd0, 1'b1, 2'b01, 20'h00123);
    probe(20'h00060, 8'd2); check("R6 write after flush", 64'(pr_idx), 64'd5);
    lk_va = 32'h0006_0ABC; lk_asid = 8'd1; #1;
    check("R6 pa", 64'(lk_pa), 64'h00123ABC);

    lk_va = 32'hA000_0000; #1; check("R9 base", 64'(lk_uncache), 64'd1);
    lk_va = 32'hBFFF_FFFF; #1; check("R9 top", 64'(lk_uncache), 64'd1);
    lk_va = 32'hE000_1000; #1; check("R9 alias", 64'(lk_uncache), 64'd1);
    lk_va = 32'h8000_0000; #1; check("R9 bit29 clear", 64'(lk_uncache), 64'd0);
    lk_va = 32'h2000_0000; #1; check("R9 bit31 clear", 64'(lk_uncache), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule